// File: doc/BRIEF.md
# Stack and Vector Sequencer

This block runs the control-flow sequences of an 8-bit accumulator processor: the start-up vector fetch, the software break, subroutine call and return, return from interrupt, and saving or restoring the accumulator or the status byte on the stack. It owns the program counter, the stack pointer and the status register. It walks each sequence as a short list of byte accesses on a synchronous memory port, one access per cycle.

A surrounding core starts a sequence with a one-cycle, one-hot command. It supplies a jump target for calls and a data byte for accumulator pushes. The block raises `busy` while it works and pulses `done` once at the end. Opcode decode, arithmetic and operand addressing belong to other blocks.

The memory port is registered. A read returns its byte one cycle after the address appears. The sequencer therefore tags each read and keeps it in a two-stage pipeline until the byte arrives.

Top module: `stack_vector_seq`

## Requirements
- R1: The stack occupies address page 0x01 at offset SP. A push writes at 0x0100+SP and then lowers SP by one. A pull raises SP by one and then reads at the new 0x0100+SP. SP wraps modulo 256: a pull at SP=0xFF reads 0x0100 and leaves SP=0x00, and a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R2: When reset is released, PC is loaded with the byte at 0xFFFC as its low half and the byte at 0xFFFD as its high half. SP becomes 0xFF, status bit 2 (interrupt disable) becomes 1 and status bit 3 (decimal) becomes 0. `done` pulses at the end of this fetch.
- R3: Break (command bit 0) first forms PC+1. It pushes that value's high byte, then its low byte, then the status byte with bit 4 set. It then sets status bit 2 and loads PC from 0xFFFE (low) and 0xFFFF (high).
- R4: Call (command bit 1) pushes PC−1, high byte first and low byte second, then sets PC to `target`.
- R5: Return (command bit 2) pulls the low byte and then the high byte, and sets PC to that value plus one, carrying across the byte boundary.
- R6: Interrupt return (command bit 3) pulls the status byte, then the PC low byte, then the PC high byte. PC takes the pulled value with no adjustment.
- R7: Accumulator push (command bit 4) stores `acc_in`. Status push (command bit 5) stores the status byte with bit 4 set and leaves the status register itself unchanged.
- R8: Accumulator pull (command bit 6) puts the byte on `acc_out`, sets status bit 1 when the byte is zero, copies byte bit 7 into status bit 7, and leaves the other status bits unchanged.
- R9: Every status pull, whether by status pull (command bit 7) or by interrupt return, loads the pulled byte with bit 5 forced to 1. Status bit 5 is never 0 after reset.
- R10: A command is accepted only while idle and only when exactly one command bit is set. Any other command value, and any command given while busy, causes no memory write and no change to PC, SP or status.
- R11: `busy` is high from acceptance until the sequence ends. `done` is high for exactly one cycle per accepted sequence, and only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; start-up fetch begins on release |
| cmd | input | 8 | One-hot command, one cycle wide |
| target | input | 16 | Jump target for call |
| acc_in | input | 8 | Byte stored by accumulator push |
| mem_rdata | input | 8 | Read byte, valid one cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |
| acc_out | output | 8 | Byte from the latest accumulator pull |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The return address is tried with a PC of 0x1200, so the minus one on call borrows into the high byte and the plus one on return carries back. A stored PC+1 of 0x1201 after interrupt return then separates the adjusted and unadjusted paths. Pulled accumulator bytes 0x00, 0x80 and 0x5A each set a different pair of zero and sign flags. Pulled status bytes 0x03, 0xC8 and 0xC1 show that bit 5 is forced while every other bit is kept. The wrap cases start from SP=0xFF and SP=0x00, and a two-bit command and a command given mid-sequence show that both are ignored.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 8;
  localparam int STEP_W = 3;

  // status bit positions
  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_B = 4;
  localparam int FL_U = 5;
  localparam int FL_N = 7;

  // sequence codes: command bit i selects code i+1, code 0 is start-up
  typedef enum logic [3:0] {
    SQ_RESET, SQ_BRK, SQ_CALL, SQ_RET, SQ_RTI,
    SQ_PHA, SQ_PHP, SQ_PLA, SQ_PLP
  } seq_e;

  typedef enum logic [1:0] {OP_PUSH, OP_PULL, OP_VEC} op_e;
  typedef enum logic [1:0] {SRC_PCH, SRC_PCL, SRC_STAT, SRC_ACC} src_e;
  typedef enum logic [1:0] {DST_LO, DST_HI, DST_STAT, DST_ACC} dst_e;

  typedef struct packed {
    op_e  op;
    src_e src;
    dst_e dst;
    logic vec_hi;
  } uop_t;
endpackage

// File: rtl/stk_microcode.sv
module stk_microcode
  import stk_pkg::*;
(
  input  seq_e              seq,
  input  logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] len,
  output uop_t              uop
);
  always_comb begin
    len = '0;
    uop = '{op: OP_PUSH, src: SRC_ACC, dst: DST_LO, vec_hi: 1'b0};
    case (seq)
      SQ_RESET: begin
        len        = 3'd2;
        uop.op     = OP_VEC;
        uop.vec_hi = step[0];
        uop.dst    = step[0] ? DST_HI : DST_LO;
      end
      SQ_BRK: begin
        len = 3'd5;
        case (step)
          3'd0:    uop.src = SRC_PCH;
          3'd1:    uop.src = SRC_PCL;
          3'd2:    uop.src = SRC_STAT;
          3'd3:    begin uop.op = OP_VEC; uop.dst = DST_LO; uop.vec_hi = 1'b0; end
          default: begin uop.op = OP_VEC; uop.dst = DST_HI; uop.vec_hi = 1'b1; end
        endcase
      end
      SQ_CALL: begin
        len     = 3'd2;
        uop.src = step[0] ? SRC_PCL : SRC_PCH;
      end
      SQ_RET: begin
        len     = 3'd2;
        uop.op  = OP_PULL;
        uop.dst = step[0] ? DST_HI : DST_LO;
      end
      SQ_RTI: begin
        len    = 3'd3;
        uop.op = OP_PULL;
        case (step)
          3'd0:    uop.dst = DST_STAT;
          3'd1:    uop.dst = DST_LO;
          default: uop.dst = DST_HI;
        endcase
      end
      SQ_PHA: begin len = 3'd1; uop.src = SRC_ACC; end
      SQ_PHP: begin len = 3'd1; uop.src = SRC_STAT; end
      SQ_PLA: begin len = 3'd1; uop.op = OP_PULL; uop.dst = DST_ACC; end
      SQ_PLP: begin len = 3'd1; uop.op = OP_PULL; uop.dst = DST_STAT; end
      default: len = '0;
    endcase
  end
endmodule

// File: rtl/stk_sp_unit.sv
module stk_sp_unit
  import stk_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SP_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pull,
  output logic [BYTE_W-1:0] sp,
  output logic [BYTE_W-1:0] sp_up
);
  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_INIT;
    else if (push) sp <= sp - 8'd1;
    else if (pull) sp <= sp + 8'd1;
  end

  assign sp_up = sp + 8'd1;

  // R1: wrap at both ends of the page
  a_r1_push_wrap: assert property (@(posedge clk) disable iff (rst)
    (push && sp == 8'h00) |=> (sp == 8'hFF));
  a_r1_pull_wrap: assert property (@(posedge clk) disable iff (rst)
    (pull && !push && sp == 8'hFF) |=> (sp == 8'h00));
endmodule

// File: rtl/stack_vector_seq.sv
module stack_vector_seq
  import stk_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [BYTE_W-1:0] SP_INIT    = 8'hFF,
  parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE,
  parameter logic [BYTE_W-1:0] STAT_RST   = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] target,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic [BYTE_W-1:0] sp,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] acc_out,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
  localparam logic [CMD_W-1:0]  ONE_C  = CMD_W'(1);
  localparam logic [BYTE_W-1:0] B_MASK = BYTE_W'(1) << FL_B;
  localparam logic [BYTE_W-1:0] U_MASK = BYTE_W'(1) << FL_U;

  state_e              state;
  seq_e                cur, sel_seq;
  logic [STEP_W-1:0]   step, len;
  uop_t                uop;
  logic                issue, cmd_ok;
  logic                pl1_v, pl2_v;
  dst_e                pl1_d, pl2_d;
  logic [BYTE_W-1:0]   lo_r, hi_r, acc_l, push_byte;
  logic [ADDR_W-1:0]   wreg, tgt_l, vec_addr;
  logic [BYTE_W-1:0]   sp_up;

  stk_microcode u_ucode (.seq(cur), .step(step), .len(len), .uop(uop));

  assign issue = (state == ST_RUN) && (step < len);

  stk_sp_unit #(.SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst(rst),
    .push(issue && uop.op == OP_PUSH),
    .pull(issue && uop.op == OP_PULL),
    .sp(sp), .sp_up(sp_up)
  );

  // command decode: exactly one bit set
  assign cmd_ok = (cmd != '0) && ((cmd & (cmd - ONE_C)) == '0);
  always_comb begin
    sel_seq = SQ_RESET;
    for (int i = 0; i < CMD_W; i++)
      if (cmd[i]) sel_seq = seq_e'(4'(i + 1));
  end

  always_comb begin
    case (uop.src)
      SRC_PCH:  push_byte = wreg[ADDR_W-1:BYTE_W];
      SRC_PCL:  push_byte = wreg[BYTE_W-1:0];
      SRC_STAT: push_byte = status | B_MASK;
      default:  push_byte = acc_l;
    endcase
  end

  assign vec_addr = ((cur == SQ_BRK) ? BRK_VEC : RST_VEC) + {{(ADDR_W-1){1'b0}}, uop.vec_hi};
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      cur       <= SQ_RESET;
      step      <= '0;
      pl1_v     <= 1'b0;
      pl2_v     <= 1'b0;
      pl1_d     <= DST_LO;
      pl2_d     <= DST_LO;
      lo_r      <= '0;
      hi_r      <= '0;
      acc_l     <= '0;
      wreg      <= '0;
      tgt_l     <= '0;
      pc        <= '0;
      status    <= STAT_RST;
      acc_out   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          done   <= 1'b0;
          mem_we <= 1'b0;
          if (cmd_ok) begin
            cur   <= sel_seq;
            step  <= '0;
            state <= ST_RUN;
            acc_l <= acc_in;
            tgt_l <= target;
            wreg  <= (sel_seq == SQ_BRK) ? pc + ONE_A : pc - ONE_A;
          end
        end
        ST_RUN: begin
          if (issue) begin
            step      <= step + 3'd1;
            mem_we    <= (uop.op == OP_PUSH);
            mem_wdata <= push_byte;
            case (uop.op)
              OP_PUSH: mem_addr <= {STACK_PAGE, sp};
              OP_PULL: mem_addr <= {STACK_PAGE, sp_up};
              default: mem_addr <= vec_addr;
            endcase
          end else begin
            mem_we <= 1'b0;
          end
          // read tags ride two stages to meet the returning byte
          pl1_v <= issue && (uop.op != OP_PUSH);
          pl1_d <= uop.dst;
          pl2_v <= pl1_v;
          pl2_d <= pl1_d;
          if (pl2_v) begin
            case (pl2_d)
              DST_LO:   lo_r <= mem_rdata;
              DST_HI:   hi_r <= mem_rdata;
              DST_STAT: status <= mem_rdata | U_MASK;
              default: begin
                acc_out      <= mem_rdata;
                status[FL_Z] <= (mem_rdata == '0);
                status[FL_N] <= mem_rdata[BYTE_W-1];
              end
            endcase
          end
          if (!issue && !pl1_v && !pl2_v) state <= ST_FIN;
        end
        default: begin
          case (cur)
            SQ_RESET: begin
              pc           <= {hi_r, lo_r};
              status[FL_I] <= 1'b1;
              status[FL_D] <= 1'b0;
            end
            SQ_BRK: begin
              pc           <= {hi_r, lo_r};
              status[FL_I] <= 1'b1;
            end
            SQ_CALL: pc <= tgt_l;
            SQ_RET:  pc <= {hi_r, lo_r} + ONE_A;
            SQ_RTI:  pc <= {hi_r, lo_r};
            default: pc <= pc;
          endcase
          mem_we <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: writes never leave the stack page
  a_r1_write_page: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:BYTE_W] == STACK_PAGE));
  // R9: bit 5 of status stays set
  a_r9_unused_bit_set: assert property (@(posedge clk) disable iff (rst)
    status[FL_U]);
  // R10: a running sequence cannot be replaced
  a_r10_hold_seq: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(cur));
  // R11: single-cycle done, only when idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_stack_vector_seq.sv
`timescale 1ns/1ps
module test_stack_vector_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd = 8'h00;
  logic [15:0] target = 16'h0000;
  logic [7:0]  acc_in = 8'h00;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pc;
  logic [7:0]  sp, status, acc_out;
  logic        busy, done;

  int nchecks = 0;
  int nerr = 0;
  int wr_cnt = 0;

  logic [7:0] stk [0:255];
  logic       pre_we = 1'b0;
  logic [7:0] pre_idx = 8'h00;
  logic [7:0] pre_val = 8'h00;

  always #2.5 clk = ~clk;

  stack_vector_seq i_stack_vector_seq (
    .clk(clk), .rst(rst), .cmd(cmd), .target(target), .acc_in(acc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .pc(pc), .sp(sp), .status(status), .acc_out(acc_out),
    .busy(busy), .done(done)
  );

  // memory model: registered read, vectors at the top of the space
  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    else if (pre_we) stk[pre_idx] <= pre_val;
    if (mem_we) wr_cnt <= wr_cnt + 1;
    case (mem_addr)
      16'hFFFC: mem_rdata <= 8'h00;
      16'hFFFD: mem_rdata <= 8'h12;
      16'hFFFE: mem_rdata <= 8'h00;
      16'hFFFF: mem_rdata <= 8'h80;
      default:  mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : 8'hEE;
    endcase
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); pre_we = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] t, input logic [7:0] a);
    @(negedge clk); cmd = c; target = t; acc_in = a;
    @(negedge clk); cmd = 8'h00;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(req, "done seen", int'(done), 1);
    @(negedge clk);
    chk("R11", "done one cycle", int'(done), 0);
  endtask

  task automatic run(input logic [7:0] c, input logic [15:0] t, input logic [7:0] a, input string req);
    send(c, t, a);
    wait_done(req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_done("R2");
    chk("R2", "pc", pc, 16'h1200);
    chk("R2", "sp", sp, 8'hFF);
    chk("R2", "I bit", status[2], 1);
    chk("R2", "D bit", status[3], 0);
    chk("R9", "bit5", status[5], 1);
    chk("R2", "no writes", wr_cnt, 0);
  endtask

  task automatic t_wrap;
    preload(8'h00, 8'h5A);
    run(8'h40, 16'h0, 8'h0, "R1");
    chk("R1", "pull wrap acc", acc_out, 8'h5A);
    chk("R1", "pull wrap sp", sp, 8'h00);
    chk("R8", "Z of 5A", status[1], 0);
    chk("R8", "N of 5A", status[7], 0);
    run(8'h10, 16'h0, 8'hC3, "R1");
    chk("R1", "push wrap byte", stk[0], 8'hC3);
    chk("R1", "push wrap sp", sp, 8'hFF);
  endtask

  task automatic t_acc_flags;
    run(8'h10, 16'h0, 8'h00, "R7");
    chk("R7", "pushed acc", stk[8'hFF], 8'h00);
    chk("R1", "push sp", sp, 8'hFE);
    run(8'h40, 16'h0, 8'h0, "R8");
    chk("R8", "acc zero", acc_out, 8'h00);
    chk("R8", "Z set", status[1], 1);
    chk("R8", "N clear", status[7], 0);
    chk("R8", "I kept", status[2], 1);
    run(8'h10, 16'h0, 8'h80, "R7");
    run(8'h40, 16'h0, 8'h0, "R8");
    chk("R8", "acc 80", acc_out, 8'h80);
    chk("R8", "Z clear", status[1], 0);
    chk("R8", "N set", status[7], 1);
    chk("R1", "sp back", sp, 8'hFF);
  endtask

  task automatic t_php;
    run(8'h20, 16'h0, 8'h0, "R7");
    chk("R7", "pushed status", stk[8'hFF], 8'hB4);
    chk("R7", "status kept", status, 8'hA4);
    chk("R7", "sp", sp, 8'hFE);
    run(8'h40, 16'h0, 8'h0, "R8");
  endtask

  task automatic t_plp;
    run(8'h10, 16'h0, 8'h03, "R9");
    run(8'h80, 16'h0, 8'h0, "R9");
    chk("R9", "status 03", status, 8'h23);
    run(8'h10, 16'h0, 8'hC8, "R9");
    run(8'h80, 16'h0, 8'h0, "R9");
    chk("R9", "status C8", status, 8'hE8);
    run(8'h10, 16'h0, 8'h03, "R9");
    run(8'h80, 16'h0, 8'h0, "R9");
    chk("R9", "sp", sp, 8'hFF);
  endtask

  task automatic t_call_ret;
    run(8'h02, 16'h4000, 8'h0, "R4");
    chk("R4", "ret hi", stk[8'hFF], 8'h11);
    chk("R4", "ret lo", stk[8'hFE], 8'hFF);
    chk("R4", "pc", pc, 16'h4000);
    chk("R4", "sp", sp, 8'hFD);
    run(8'h04, 16'h0, 8'h0, "R5");
    chk("R5", "pc", pc, 16'h1200);
    chk("R5", "sp", sp, 8'hFF);
  endtask

  task automatic t_brk;
    int w0 = wr_cnt;
    run(8'h01, 16'h0, 8'h0, "R3");
    chk("R3", "hi", stk[8'hFF], 8'h12);
    chk("R3", "lo", stk[8'hFE], 8'h01);
    chk("R3", "status byte", stk[8'hFD], 8'h33);
    chk("R3", "sp", sp, 8'hFC);
    chk("R3", "pc", pc, 16'h8000);
    chk("R3", "status", status, 8'h27);
    chk("R3", "writes", wr_cnt - w0, 3);
  endtask

  task automatic t_rti;
    preload(8'hFD, 8'hC1);
    run(8'h08, 16'h0, 8'h0, "R6");
    chk("R6", "status", status, 8'hE1);
    chk("R6", "pc", pc, 16'h1201);
    chk("R6", "sp", sp, 8'hFF);
  endtask

  task automatic t_ignore_multi;
    int w0 = wr_cnt;
    int seen = 0;
    send(8'h30, 16'h0, 8'h77);
    repeat (12) begin
      @(negedge clk);
      if (busy || done) seen++;
    end
    chk("R10", "no activity", seen, 0);
    chk("R10", "no writes", wr_cnt - w0, 0);
    chk("R10", "sp", sp, 8'hFF);
    chk("R10", "pc", pc, 16'h1201);
    chk("R10", "status", status, 8'hE1);
  endtask

  task automatic t_ignore_busy;
    int w0 = wr_cnt;
    int dones = 0;
    int busy_seen = 0;
    send(8'h01, 16'h0, 8'h0);
    busy_seen = int'(busy);
    cmd = 8'h10; acc_in = 8'h99;
    @(negedge clk);
    @(negedge clk);
    cmd = 8'h00;
    repeat (40) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R11", "busy after accept", busy_seen, 1);
    chk("R11", "done count", dones, 1);
    chk("R10", "writes", wr_cnt - w0, 3);
    chk("R10", "sp", sp, 8'hFC);
    chk("R10", "pc", pc, 16'h8000);
    chk("R3", "status byte", stk[8'hFD], 8'hF1);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_acc_flags();
    t_php();
    t_plp();
    t_call_ret();
    t_brk();
    t_rti();
    t_ignore_multi();
    t_ignore_busy();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule